// File: doc/BRIEF.md
# Predicated Vector Load/Store Address Sequencer

This block turns one vectorised load or store into a stream of per-element memory requests. A `start` pulse captures the operation's setup: the vector length, the source and destination predicate masks, a flag for each operand saying whether it is scalar or vector, the addressing selects, the immediate, the shift amount, the access width and the cache-inhibit flag. The block then walks the element positions and sends one request per active element over a valid/ready handshake.

Each request carries a 64-bit effective address, the destination element index, and an optional write of that address back to an update register at its own index. The base register is read through a simple combinational register-file port. For a vector base the port reads element `i`; for a scalar base it always reads element 0.

Three counters advance on their own: the source index, the destination index and the update index. Each vector counter skips positions whose predicate bit is clear. The addressing form is chosen by a fixed priority. When the chosen form is splat (one address for every element), the cache-inhibit flag decides between a single broadcast read and one read per element.

Top module: `vls_addr_seq`

## Requirements
- R1: A vector operand's index skips positions whose mask bit is clear: `dst_mask` for the destination, `src_mask` for a vector base and for a vector update index. A scalar destination or scalar update index stays at 0. The source index steps by one per request without skipping when the base is scalar.
- R2: In unit-stride form the address is base + `imm` + (i << `width_log2`). `width_log2` values 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes.
- R3: In element-stride form the address is base + i × `imm`.
- R4: When `shift_sel` = 1, the address is base + ((i × `imm`) << `shamt`). The base is read at element i when the base is a vector, and at element 0 otherwise.
- R5: When the base is a vector and `shift_sel` = 0, the address is `rf_base` read at element i, plus `imm` unmodified.
- R6: The form is chosen in this priority order:
  1. shifted (`shift_sel` = 1);
  2. indexed (vector base);
  3. unit stride (`stride_sel` = 0);
  4. element stride (`imm` ≠ 0).
  If none applies, the form is splat, with address = base for every element.
- R7: With a scalar destination the sequence ends after the first accepted request, and `req_dst_idx` = 0.
- R8: A splat with `cache_inh` = 0 issues exactly one request, with `req_bcast` = 1. A splat with `cache_inh` = 1 issues one request per active element, in increasing order, with `req_bcast` = 0. Every other form has `req_bcast` = 0.
- R9: Each request has `req_upd_we` = `upd_en` and `req_upd_idx` = the current update index.
- R10: The sequence ends when any checked index (source, destination, or update when enabled) reaches `vl`. After the end, `done` pulses high for exactly one cycle, and no request is shown from then until the next start. With `vl` = 0 no request is issued. `req_valid` and `done` are low after reset.
- R11: Address arithmetic is 64 bits wide and wraps modulo 2^64.
- R12: While `req_valid` is high and `req_ready` is low, the request stays valid and its fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence; accepted only while idle |
| vl | input | $clog2(MAXVL+1) | Vector length |
| src_mask | input | MAXVL | Source predicate |
| dst_mask | input | MAXVL | Destination predicate |
| base_is_vec | input | 1 | Base operand is a vector |
| dst_is_vec | input | 1 | Destination is a vector |
| upd_en | input | 1 | Write the address back to the update register |
| upd_is_vec | input | 1 | Update register is a vector |
| shift_sel | input | 1 | Select shifted addressing |
| stride_sel | input | 1 | 0 selects unit stride, 1 selects element stride |
| imm | input | 64 | Immediate offset |
| shamt | input | 6 | Shift amount for shifted addressing |
| width_log2 | input | 2 | log2 of the access width in bytes |
| cache_inh | input | 1 | Cache-inhibited access |
| rf_idx | output | $clog2(MAXVL) | Base register element to read |
| rf_base | input | 64 | Base register value at `rf_idx` |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_addr | output | 64 | Effective address |
| req_dst_idx | output | $clog2(MAXVL) | Destination element index |
| req_bcast | output | 1 | Copy the single read to all destination elements |
| req_upd_we | output | 1 | Update-register write enable |
| req_upd_idx | output | $clog2(MAXVL) | Update element index |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with MAXVL = 4. This makes every pair of 4-bit source and destination masks reachable for each of the six addressing cases: unit, element stride, shifted, indexed, inhibited splat and broadcast splat. Each case runs with both scalar and vector destinations. The vector length ranges from 0 to 4, and update off, scalar and vector are all used. A pseudo-random ready pattern exercises stalls, and a dedicated run near the top of the 64-bit space exercises address wrap.

// File: rtl/vls_addr_seq.sv
module vls_addr_seq #(
  parameter int MAXVL = 8,
  localparam int IW = $clog2(MAXVL),
  localparam int CW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             base_is_vec,
  input  logic             dst_is_vec,
  input  logic             upd_en,
  input  logic             upd_is_vec,
  input  logic             shift_sel,
  input  logic             stride_sel,
  input  logic [63:0]      imm,
  input  logic [5:0]       shamt,
  input  logic [1:0]       width_log2,
  input  logic             cache_inh,
  output logic [IW-1:0]    rf_idx,
  input  logic [63:0]      rf_base,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [63:0]      req_addr,
  output logic [IW-1:0]    req_dst_idx,
  output logic             req_bcast,
  output logic             req_upd_we,
  output logic [IW-1:0]    req_upd_idx,
  output logic             done
);

  logic             run, done_q;
  logic [CW-1:0]    c_vl, si, di, ui;
  logic [MAXVL-1:0] c_sm, c_dm;
  logic             c_bv, c_dv, c_ue, c_uv, c_shf, c_els, c_ci;
  logic [63:0]      c_imm;
  logic [5:0]       c_sh;
  logic [1:0]       c_w;

  function automatic logic [CW-1:0] seek(input logic [MAXVL-1:0] m, input logic [CW-1:0] from);
    seek = CW'(MAXVL);
    for (int k = MAXVL - 1; k >= 0; k--)
      if (CW'(k) >= from && m[k]) seek = CW'(k);
  endfunction

  logic [CW-1:0] ei, ej, eu;
  logic          live, fire, last, splat, imm_nz;
  logic [63:0]   eix, prod;

  assign ei     = c_bv ? seek(c_sm, si) : si;
  assign ej     = c_dv ? seek(c_dm, di) : di;
  assign eu     = c_uv ? seek(c_sm, ui) : ui;
  assign live   = run && (ei < c_vl) && (ej < c_vl) && (!c_ue || eu < c_vl);
  assign imm_nz = |c_imm;
  assign splat  = !c_shf && !c_bv && c_els && !imm_nz;
  assign eix    = 64'(ei);
  assign prod   = eix * c_imm;

  assign rf_idx      = c_bv ? ei[IW-1:0] : '0;
  assign req_valid   = live;
  assign req_dst_idx = ej[IW-1:0];
  assign req_upd_idx = eu[IW-1:0];
  assign req_upd_we  = live && c_ue;
  assign req_bcast   = splat && !c_ci;
  assign done        = done_q;
  assign fire        = live && req_ready;
  assign last        = !c_dv || req_bcast;

  always_comb begin
    if (c_shf)        req_addr = rf_base + (prod << c_sh);
    else if (c_bv)    req_addr = rf_base + c_imm;
    else if (!c_els)  req_addr = rf_base + c_imm + (eix << c_w);
    else if (imm_nz)  req_addr = rf_base + prod;
    else              req_addr = rf_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      done_q <= 1'b0;
      si     <= '0;
      di     <= '0;
      ui     <= '0;
      c_vl   <= '0;
      c_sm   <= '0;
      c_dm   <= '0;
      c_bv   <= 1'b0;
      c_dv   <= 1'b0;
      c_ue   <= 1'b0;
      c_uv   <= 1'b0;
      c_shf  <= 1'b0;
      c_els  <= 1'b0;
      c_ci   <= 1'b0;
      c_imm  <= '0;
      c_sh   <= '0;
      c_w    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        if (start) begin
          run   <= 1'b1;
          si    <= '0;
          di    <= '0;
          ui    <= '0;
          c_vl  <= vl;
          c_sm  <= src_mask;
          c_dm  <= dst_mask;
          c_bv  <= base_is_vec;
          c_dv  <= dst_is_vec;
          c_ue  <= upd_en;
          c_uv  <= upd_is_vec;
          c_shf <= shift_sel;
          c_els <= stride_sel;
          c_ci  <= cache_inh;
          c_imm <= imm;
          c_sh  <= shamt;
          c_w   <= width_log2;
        end
      end else if (fire) begin
        si <= ei + CW'(1);
        if (c_dv) di <= ej + CW'(1);
        if (c_uv) ui <= eu + CW'(1);
        if (last) begin
          run    <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (!live) begin
        run    <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk #(
  parameter int MAXVL = 8,
  localparam int IW = $clog2(MAXVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [63:0]      req_addr,
  input logic [IW-1:0]    req_dst_idx,
  input logic             req_bcast,
  input logic             done,
  input logic             c_dv,
  input logic             c_ci,
  input logic [MAXVL-1:0] c_dm
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_dst_idx)); // R12

  AST_DST_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && c_dv |-> c_dm[req_dst_idx]); // R1

  AST_DST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && c_dv |=> !req_valid || req_dst_idx > $past(req_dst_idx)); // R1

  AST_SCALAR_DST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !c_dv |-> req_dst_idx == '0); // R7

  AST_BCAST_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_bcast |-> !c_ci); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind vls_addr_seq vls_addr_seq_chk #(.MAXVL(MAXVL)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_dst_idx(req_dst_idx), .req_bcast(req_bcast),
  .done(done), .c_dv(c_dv), .c_ci(c_ci), .c_dm(c_dm)
);

// File: tb/vls_addr_seq_tb_top.sv
module vls_addr_seq_tb_top;
  localparam int PERIOD = 10;
  localparam int MAXVL  = 4;
  localparam int IW = $clog2(MAXVL);
  localparam int CW = $clog2(MAXVL + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] vl = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic base_is_vec = 0, dst_is_vec = 0, upd_en = 0, upd_is_vec = 0;
  logic shift_sel = 0, stride_sel = 0, cache_inh = 0, req_ready = 0;
  logic [63:0] imm = '0;
  logic [5:0] shamt = '0;
  logic [1:0] width_log2 = '0;
  logic [IW-1:0] rf_idx, req_dst_idx, req_upd_idx;
  logic [63:0] rf_base, req_addr;
  logic req_valid, req_bcast, req_upd_we, done;

  logic [63:0] regs [MAXVL];
  assign rf_base = regs[rf_idx];

  always #(PERIOD/2) clk = ~clk;

  vls_addr_seq #(.MAXVL(MAXVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .src_mask(src_mask),
    .dst_mask(dst_mask), .base_is_vec(base_is_vec), .dst_is_vec(dst_is_vec),
    .upd_en(upd_en), .upd_is_vec(upd_is_vec), .shift_sel(shift_sel),
    .stride_sel(stride_sel), .imm(imm), .shamt(shamt), .width_log2(width_log2),
    .cache_inh(cache_inh), .rf_idx(rf_idx), .rf_base(rf_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_dst_idx(req_dst_idx), .req_bcast(req_bcast), .req_upd_we(req_upd_we),
    .req_upd_idx(req_upd_idx), .done(done)
  );

  int checks = 0, failures = 0;
  logic [7:0] lfsr = 8'h5a;

  logic [63:0] e_addr [MAXVL];
  int e_dst [MAXVL], e_upd [MAXVL];
  logic e_bc [MAXVL];
  int e_n;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] base_at(input int k);
    return base_is_vec ? regs[k] : regs[0];
  endfunction

  task automatic build_expected();
    int i = 0, j = 0, u = 0;
    bit bc;
    logic [63:0] a, bi;
    e_n = 0;
    bc = !shift_sel && !base_is_vec && stride_sel && imm == 0 && !cache_inh;
    forever begin
      if (base_is_vec) while (i < int'(vl) && !src_mask[i]) i++;
      if (dst_is_vec) while (j < int'(vl) && !dst_mask[j]) j++;
      if (upd_en && upd_is_vec) while (u < int'(vl) && !src_mask[u]) u++;
      if (i >= int'(vl) || j >= int'(vl) || (upd_en && u >= int'(vl))) break;
      bi = 64'(i);
      if (shift_sel) a = base_at(i) + ((bi * imm) << shamt);
      else if (base_is_vec) a = regs[i] + imm;
      else if (!stride_sel) a = regs[0] + imm + bi * (64'd1 << width_log2);
      else if (imm != 0) a = regs[0] + bi * imm;
      else a = regs[0];
      e_addr[e_n] = a; e_dst[e_n] = j; e_upd[e_n] = u; e_bc[e_n] = bc;
      e_n++;
      if (!dst_is_vec || bc) break;
      i++;
      if (dst_is_vec) j++;
      if (upd_is_vec) u++;
    end
  endtask

  task automatic run_seq(input string atag);
    int n = 0, cyc = 0;
    bit prev_stall = 0, got_done = 0;
    logic [63:0] prev_addr = '0;
    build_expected();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 64) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (done) begin
        chk(!req_valid, "R10 valid during done", 64'(req_valid), 0);
        got_done = 1;
        break;
      end
      if (req_valid) begin
        if (prev_stall) chk(req_addr == prev_addr, "R12 stall hold", req_addr, prev_addr);
        if (n >= e_n) chk(0, "R10 extra request", 64'(n), 64'(e_n));
        else begin
          chk(req_addr == e_addr[n], atag, req_addr, e_addr[n]);
          chk(int'(req_dst_idx) == e_dst[n], dst_is_vec ? "R1 dst idx" : "R7 dst idx",
              64'(req_dst_idx), 64'(e_dst[n]));
          chk(req_bcast == e_bc[n], "R8 bcast", 64'(req_bcast), 64'(e_bc[n]));
          chk(req_upd_we == upd_en, "R9 upd we", 64'(req_upd_we), 64'(upd_en));
          if (upd_en) chk(int'(req_upd_idx) == e_upd[n], "R9 upd idx", 64'(req_upd_idx), 64'(e_upd[n]));
        end
        req_ready = lfsr[0] | lfsr[1];
        prev_stall = !req_ready;
        prev_addr = req_addr;
        if (req_ready) n++;
      end else begin
        req_ready = lfsr[0];
        prev_stall = 0;
      end
      @(negedge clk);
      cyc++;
    end
    chk(got_done, "R10 done seen", 64'(got_done), 1);
    chk(n == e_n, "R10 request count", 64'(n), 64'(e_n));
    @(negedge clk);
    chk(!done, "R10 done single pulse", 64'(done), 0);
  endtask

  initial begin
    #(PERIOD * 190000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string tags [6] = '{"R2 unit addr", "R3 els addr", "R4 shift addr",
                        "R5 indexed addr", "R8 ci splat addr", "R6 splat addr"};
    for (int k = 0; k < MAXVL; k++) regs[k] = 64'h1000 * (k + 1) + 64'(k * 3);
    repeat (3) @(negedge clk);
    chk(!req_valid, "R10 reset valid", 64'(req_valid), 0);
    chk(!done, "R10 reset done", 64'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 6; m++)
      for (int dv = 0; dv < 2; dv++)
        for (int sm = 0; sm < 16; sm++)
          for (int dm = 0; dm < 16; dm++) begin
            int uc;
            src_mask = 4'(sm); dst_mask = 4'(dm);
            vl = CW'((sm + dm + m) % 5);
            dst_is_vec = dv[0];
            uc = (sm ^ dm ^ m) % 3;
            upd_en = (uc != 0); upd_is_vec = (uc == 2);
            width_log2 = 2'((sm + dm) % 4);
            shamt = 6'(dm % 3 + 1);
            shift_sel = (m == 2);
            base_is_vec = (m == 3) || (m == 2 && dm[0]);
            stride_sel = (m == 0) ? 1'b0 : (m == 3 || m == 2) ? 1'(sm & 1) : 1'b1;
            cache_inh = (m == 4) ? 1'b1 : (m == 5) ? 1'b0 : 1'(dm & 1);
            case (m)
              0: imm = 64'd16 + 64'(sm);
              1: imm = 64'd24 + 64'(dm);
              2: imm = 64'd3;
              3: imm = 64'd8;
              default: imm = 64'd0;
            endcase
            run_seq(tags[m]);
          end
    for (int k = 0; k < MAXVL; k++) regs[k] = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(k);
    for (int w = 0; w < 4; w++) begin
      src_mask = '1; dst_mask = '1; vl = CW'(MAXVL);
      dst_is_vec = 1; upd_en = 1; upd_is_vec = 1;
      shift_sel = 0; base_is_vec = 0; stride_sel = 0; cache_inh = 0;
      imm = 64'd8; width_log2 = 2'(w); shamt = 0;
      run_seq("R11 wrap addr");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule